// File: doc/BRIEF.md
# Parity Thinning Stage for Fine Rate Steps

This stage follows a systematic forward error correction encoder. Each input beat carries one coded bit and a tag saying whether the bit is systematic or parity. A keep setting `n` chooses how many parity bits out of every window of 16 are sent on. Systematic bits always go through. Dropped parity bits are consumed from the input and never reach the output. The overall code rate therefore moves from the coarse encoder rate `r` to `r / (r + p·(1 - r))` with `p = n/16`.

Nine ratios, from 16/16 down to 8/16, fill the gaps between neighbouring coarse rates. A frame can be made a little longer or shorter with them so that little or no padding is needed. The parity bits that are kept are spread evenly through each window by a running accumulator. The accumulator restarts at every frame start, and the setting is captured once per frame. Kept bits leave through a one-deep registered valid/ready stage. When the last beat of a frame is accepted, the block reports how many bits of that frame were sent.

Top module: `punct_unit`

## Requirements
- R1: Every accepted systematic beat (`s_is_par`=0) appears on the output in input order, with its bit value unchanged and `m_is_par`=0.
- R2: Parity beats are numbered from 0 starting at the frame's first beat. An accumulator starts at 0. For each parity beat it adds `n`. If the sum reaches 16, the beat is kept and 16 is subtracted; otherwise the beat is dropped. Every aligned group of 16 parity beats in a frame therefore forwards exactly `n` beats.
- R3: `keep_req` is sampled only on a beat with `s_first`=1. The sampled value holds for the rest of that frame, and changes to `keep_req` on the other beats have no effect.
- R4: `keep_req` is 5 bits wide. A request below 8 acts as 8 and a request above 16 acts as 16.
- R5: With an effective setting of 16, every parity beat is forwarded. While `m_ready` is high, `s_ready` stays high on every cycle, so no bubbles are inserted.
- R6: The accumulator restarts at 0 on every `s_first` beat, even when the previous frame ended part-way through a window.
- R7: While `m_valid`=1 and `m_ready`=0, the output beat stays valid and its bit and tag do not change. `s_ready` is high whenever the output register is empty or is being emptied. No kept beat is lost or duplicated.
- R8: One cycle after the beat with `s_last`=1 is accepted, `frm_done` is high for one cycle. `frm_count` then equals the number of beats of that frame that were forwarded. `frm_done` is low at all other times.
- R9: While reset is active and just after it, `m_valid`=0, `frm_done`=0 and `s_ready`=1.
- R10: Beats accepted after reset and before the first `s_first` beat use a setting of 16, so all of them are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with `s_valid` |
| s_bit | input | 1 | Coded bit |
| s_is_par | input | 1 | 1 = parity bit, 0 = systematic bit |
| s_first | input | 1 | First beat of a frame; restarts the pattern and samples `keep_req` |
| s_last | input | 1 | Last beat of a frame |
| keep_req | input | 5 | Requested parity bits kept per 16 (clamped to 8..16) |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_bit | output | 1 | Forwarded coded bit |
| m_is_par | output | 1 | Tag of the forwarded bit |
| frm_done | output | 1 | One-cycle pulse after a frame's last beat is accepted |
| frm_count | output | 16 | Number of bits forwarded in the frame just ended |

## Verification
The bench builds the block with its default parameters: a window of 16, a minimum keep of 8 and a 16-bit frame counter. With these values every one of the 32 request codes can be driven, including values past both clamp limits. Frames of up to 40 beats cross window boundaries and end part-way through a window. The frame counter never wraps. A behavioural model tracks the accumulator and the expected output queue, and random downstream backpressure exercises the hold behaviour of the output stage.

// File: rtl/punc_pkg.sv
package punc_pkg;

  // One beat held in the output register: the coded bit and its parity tag.
  typedef struct packed {
    logic dbit;
    logic is_par;
  } beat_t;

  // Limit a requested keep count to the supported range.
  function automatic int clamp_keep(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // A parity beat is kept when the running sum reaches the window size.
  function automatic bit window_keep(input int acc, input int n, input int win);
    return (acc + n) >= win;
  endfunction

  // Next accumulator value after one parity beat.
  function automatic int window_next(input int acc, input int n, input int win);
    int s;
    s = acc + n;
    return (s >= win) ? (s - win) : s;
  endfunction

endpackage

// File: rtl/punc_rate_hold.sv
module punc_rate_hold
  import punc_pkg::*;
#(
  parameter int WIN      = 16,
  parameter int MIN_KEEP = 8,
  parameter int RW       = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          first,
  input  logic [RW-1:0] req,
  output logic [RW-1:0] n_eff
);

  logic [RW-1:0] held_q;
  logic [RW-1:0] req_lim;

  assign req_lim = RW'(clamp_keep(int'(req), MIN_KEEP, WIN));

  // The first beat of a frame uses the new request directly; later beats use the held value.
  assign n_eff = first ? req_lim : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= RW'(WIN);
    end else if (fire && first) begin
      held_q <= req_lim;
    end
  end

endmodule

// File: rtl/punc_phase_acc.sv
module punc_phase_acc
  import punc_pkg::*;
#(
  parameter int WIN   = 16,
  parameter int RW    = $clog2(WIN + 1),
  parameter int ACC_W = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          first,
  input  logic          is_par,
  input  logic [RW-1:0] n_eff,
  output logic          keep
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_base;
  logic             par_keep;

  // The pattern phase restarts on the first beat of a frame.
  assign acc_base = first ? '0 : acc_q;
  assign par_keep = window_keep(int'(acc_base), int'(n_eff), WIN);
  assign keep     = !is_par || par_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (fire) begin
      if (is_par) begin
        acc_q <= ACC_W'(window_next(int'(acc_base), int'(n_eff), WIN));
      end else if (first) begin
        acc_q <= '0;
      end
    end
  end

endmodule

// File: rtl/punc_frame_tally.sv
module punc_frame_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             first,
  input  logic             last,
  input  logic             kept,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] total;

  assign base  = first ? '0 : run_q;
  assign total = base + CNT_W'(kept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= fire && last;
      if (fire) begin
        run_q <= last ? '0 : total;
        if (last) count <= total;
      end
    end
  end

endmodule

// File: rtl/punc_out_reg.sv
module punc_out_reg
  import punc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t beat_in,
  output logic  room,
  output logic  m_valid,
  input  logic  m_ready,
  output beat_t beat_out
);

  // The register can take a new beat when it is empty or is being emptied.
  assign room = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      beat_out <= '0;
    end else if (room) begin
      m_valid <= load;
      if (load) beat_out <= beat_in;
    end
  end

endmodule

// File: rtl/punct_unit.sv
module punct_unit
  import punc_pkg::*;
#(
  parameter int WIN      = 16,
  parameter int MIN_KEEP = 8,
  parameter int CNT_W    = 16,
  localparam int RW      = $clog2(WIN + 1),
  localparam int ACC_W   = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_bit,
  input  logic             s_is_par,
  input  logic             s_first,
  input  logic             s_last,
  input  logic [RW-1:0]    keep_req,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_bit,
  output logic             m_is_par,
  output logic             frm_done,
  output logic [CNT_W-1:0] frm_count
);

  // Named internal events, also watched by the bound checker.
  logic          fire;
  logic [RW-1:0] n_eff;
  logic          keep_par;
  logic          load;
  beat_t         beat_in;
  beat_t         beat_out;

  assign fire    = s_valid && s_ready;
  assign load    = fire && keep_par;
  assign beat_in = '{dbit: s_bit, is_par: s_is_par};

  punc_rate_hold #(.WIN(WIN), .MIN_KEEP(MIN_KEEP), .RW(RW)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .first (s_first),
    .req   (keep_req),
    .n_eff (n_eff)
  );

  punc_phase_acc #(.WIN(WIN), .RW(RW), .ACC_W(ACC_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .first  (s_first),
    .is_par (s_is_par),
    .n_eff  (n_eff),
    .keep   (keep_par)
  );

  punc_frame_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .first (s_first),
    .last  (s_last),
    .kept  (keep_par),
    .done  (frm_done),
    .count (frm_count)
  );

  punc_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .beat_in  (beat_in),
    .room     (s_ready),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .beat_out (beat_out)
  );

  assign m_bit    = beat_out.dbit;
  assign m_is_par = beat_out.is_par;

endmodule

// File: rtl/punc_checker.sv
module punc_checker #(
  parameter int WIN      = 16,
  parameter int MIN_KEEP = 8,
  parameter int RW       = $clog2(WIN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          s_bit,
  input logic          s_is_par,
  input logic          s_first,
  input logic          s_last,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_bit,
  input logic          m_is_par,
  input logic          frm_done,
  input logic [RW-1:0] n_eff,
  input logic          keep_par
);

  logic fire;
  assign fire = s_valid && s_ready;

  // R1: a systematic beat shows up on the output in the next cycle, unchanged.
  a_r1_sys_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !s_is_par |=> m_valid && !m_is_par && (m_bit == $past(s_bit)))
    else $error("a_r1_sys_forwarded");

  // R4: the effective setting stays within the clamp range.
  a_r4_setting_range: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (int'(n_eff) >= MIN_KEEP) && (int'(n_eff) <= WIN))
    else $error("a_r4_setting_range");

  // R5: with the full setting, every parity beat reaches the output.
  a_r5_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    fire && s_is_par && (int'(n_eff) == WIN) |=> m_valid && m_is_par)
    else $error("a_r5_full_keep");

  // R7: a stalled output beat stays put.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_bit) && $stable(m_is_par))
    else $error("a_r7_hold");

  // R8: the frame pulse only follows an accepted last beat.
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(s_valid && s_ready && s_last))
    else $error("a_r8_done_after_last");

  // R8: an accepted last beat always yields the pulse.
  a_r8_last_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    fire && s_last |=> frm_done)
    else $error("a_r8_last_gives_done");

  // R2: count kept parity beats per aligned window of WIN within a frame.
  int par_idx;
  int kept_cnt;
  int idx_base;
  int kept_base;

  always_comb begin
    idx_base  = s_first ? 0 : par_idx;
    kept_base = s_first ? 0 : kept_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_idx  <= 0;
      kept_cnt <= 0;
    end else if (fire) begin
      if (s_is_par) begin
        if (idx_base == WIN - 1) begin
          a_r2_window_count: assert (kept_base + int'(keep_par) == int'(n_eff))
            else $error("a_r2_window_count");
          par_idx  <= 0;
          kept_cnt <= 0;
        end else begin
          par_idx  <= idx_base + 1;
          kept_cnt <= kept_base + int'(keep_par);
        end
      end else if (s_first) begin
        par_idx  <= 0;
        kept_cnt <= 0;
      end
    end
  end

endmodule

bind punct_unit punc_checker #(.WIN(WIN), .MIN_KEEP(MIN_KEEP), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_bit    (s_bit),
  .s_is_par (s_is_par),
  .s_first  (s_first),
  .s_last   (s_last),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_bit    (m_bit),
  .m_is_par (m_is_par),
  .frm_done (frm_done),
  .n_eff    (n_eff),
  .keep_par (keep_par)
);

// File: tb/tb_punct_unit.sv
`timescale 1ns/1ps
module tb_punct_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_bit = 1'b0;
  logic        s_is_par = 1'b0;
  logic        s_first = 1'b0;
  logic        s_last = 1'b0;
  logic [4:0]  keep_req = 5'd16;
  logic        m_ready = 1'b1;
  logic        bp_en = 1'b0;
  wire         s_ready;
  wire         m_valid;
  wire         m_bit;
  wire         m_is_par;
  wire         frm_done;
  wire [15:0]  frm_count;

  always #2.5 clk = ~clk;

  punct_unit dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .s_is_par(s_is_par), .s_first(s_first), .s_last(s_last), .keep_req(keep_req),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit), .m_is_par(m_is_par),
    .frm_done(frm_done), .frm_count(frm_count)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model state
  int exp_q[$];
  int mod_acc = 0;
  int mod_n = 16;
  int mod_cnt = 0;
  bit will_fire = 0;
  bit exp_done = 0;
  int exp_cnt = 0;
  int seen_count = -1;
  bit prev_stall = 0;
  bit prev_b = 0;
  bit prev_p = 0;
  bit chk_nobubble = 0;
  bit mod_keep = 0;
  int e = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampk(input int r);
    if (r < 8) return 8;
    if (r > 16) return 16;
    return r;
  endfunction

  // Monitor and cycle-by-cycle model, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      will_fire  = 0;
      exp_done   = 0;
      prev_stall = 0;
    end else begin
      if (exp_done) begin
        check(frm_done == 1'b1, "R8 done pulse", int'(frm_done), 1);
        check(int'(frm_count) == exp_cnt, "R8 frame count", int'(frm_count), exp_cnt);
      end else if (frm_done) begin
        check(1'b0, "R8 spurious done", 1, 0);
      end
      if (frm_done) seen_count = int'(frm_count);
      exp_done = 0;

      if (prev_stall)
        check(m_valid && (m_bit == prev_b) && (m_is_par == prev_p), "R7 stalled beat held",
              int'({m_valid, m_bit, m_is_par}), int'({1'b1, prev_b, prev_p}));

      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected output beat", int'({m_is_par, m_bit}), -1);
        end else begin
          e = exp_q.pop_front();
          check(int'({m_is_par, m_bit}) == e, "R1 R2 output beat", int'({m_is_par, m_bit}), e);
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_b     = m_bit;
      prev_p     = m_is_par;

      if (chk_nobubble && s_valid) check(s_ready == 1'b1, "R5 no bubble", int'(s_ready), 1);

      will_fire = s_valid && s_ready;
      if (will_fire) begin
        if (s_first) begin
          mod_n   = clampk(int'(keep_req));
          mod_acc = 0;
          mod_cnt = 0;
        end
        mod_keep = 1;
        if (s_is_par) begin
          mod_acc = mod_acc + mod_n;
          if (mod_acc >= 16) mod_acc = mod_acc - 16;
          else mod_keep = 0;
        end
        if (mod_keep) begin
          exp_q.push_back(int'({s_is_par, s_bit}));
          mod_cnt++;
        end
        if (s_last) begin
          exp_done = 1;
          exp_cnt  = mod_cnt;
          mod_cnt  = 0;
        end
      end
    end
  end

  // Downstream ready: always high or pseudo-random
  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    forever begin
      @(posedge clk);
      #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      m_ready = bp_en ? (lf[0] | lf[2]) : 1'b1;
    end
  end

  task automatic beat(input bit b, input bit p, input bit f, input bit l, input int req);
    s_valid  = 1'b1;
    s_bit    = b;
    s_is_par = p;
    s_first  = f;
    s_last   = l;
    keep_req = 5'(req);
    @(posedge clk);
    while (!will_fire) @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Frame of parity beats only; first beat uses req, later beats use later_req
  task automatic par_frame(input int len, input int req, input int later_req, input bit with_first);
    for (int i = 0; i < len; i++)
      beat(bit'(i % 3 == 1), 1'b1, with_first && (i == 0), i == len - 1, (i == 0) ? req : later_req);
    idle(6);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      check(1'b0, "R8 watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(m_valid == 1'b0, "R9 m_valid in reset", int'(m_valid), 0);
    check(frm_done == 1'b0, "R9 frm_done in reset", int'(frm_done), 0);
    check(s_ready == 1'b1, "R9 s_ready in reset", int'(s_ready), 1);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(2);

    // R10: no frame start yet, so the setting is 16 and all 4 parity beats pass
    seen_count = -1;
    par_frame(4, 8, 8, 1'b0);
    check(seen_count == 4, "R10 count before first frame start", seen_count, 4);

    // R2: 32 parity beats at 12/16 keep 24
    seen_count = -1;
    par_frame(32, 12, 12, 1'b1);
    check(seen_count == 24, "R2 count at 12 of 16", seen_count, 24);

    // R4: clamp below and above
    seen_count = -1;
    par_frame(32, 3, 3, 1'b1);
    check(seen_count == 16, "R4 low request clamps to 8", seen_count, 16);
    seen_count = -1;
    par_frame(32, 31, 31, 1'b1);
    check(seen_count == 32, "R4 high request clamps to 16", seen_count, 32);

    // R3: the request changes mid-frame and is ignored
    seen_count = -1;
    par_frame(32, 10, 16, 1'b1);
    check(seen_count == 20, "R3 mid-frame request ignored", seen_count, 20);

    // R6: an odd-length frame leaves the phase half-way; the next frame restarts it
    seen_count = -1;
    par_frame(5, 8, 8, 1'b1);
    check(seen_count == 2, "R6 five parity beats at 8 of 16", seen_count, 2);
    seen_count = -1;
    par_frame(1, 8, 8, 1'b1);
    check(seen_count == 0, "R6 phase restarted at frame start", seen_count, 0);

    // R5: full setting, no backpressure, mixed beats, no bubbles
    chk_nobubble = 1;
    seen_count = -1;
    for (int i = 0; i < 24; i++)
      beat(bit'(i % 2), bit'(i % 4 != 0), i == 0, i == 23, 16);
    chk_nobubble = 0;
    idle(6);
    check(seen_count == 24, "R5 all beats forwarded", seen_count, 24);

    // R1 R2 R7: random frames under backpressure, checked by the model
    bp_en = 1'b1;
    for (int f = 0; f < 14; f++) begin
      int len;
      int req;
      len = $urandom_range(1, 40);
      req = $urandom_range(0, 31);
      for (int i = 0; i < len; i++)
        beat(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0), i == 0, i == len - 1,
             (i == 0) ? req : $urandom_range(0, 31));
      if (f % 3 == 0) idle(3);
    end
    bp_en = 1'b0;
    idle(40);
    check(exp_q.size() == 0, "R7 every kept beat delivered", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule